// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent 32-bit down-counters behind a small synchronous register port. Every clock cycle, each enabled counter steps down by one. A counter can run in one of two modes. In periodic mode it refills itself from a reload register after it passes zero. In one-shot mode it fires once and then parks at zero. Software can also load the live count directly, at any time, to start a new interval.

Each expiry sets a sticky cause bit. A separate mask decides which cause bits reach the single interrupt line. A counter whose count and reload are both all-ones, and whose interrupt is masked, serves as a free-running time base. Inverting its count gives a value that rises by one per cycle.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The control word sits at address 0x00. Bit 2i enables counter i and bit 2i+1 selects periodic reload for counter i. Only bits 3:0 are stored and the rest read as zero. An address that matches no register reads as zero and a write to it has no effect.
- R3: On each clock edge, a counter that is enabled and nonzero decreases by exactly one. With count and reload both 0xFFFFFFFF, the bitwise inverse of the count rises by one per cycle.
- R4: An enabled periodic counter sitting at zero loads its reload value on the next edge and signals an expiry. A reload of N therefore gives one expiry every N+1 cycles.
- R5: An enabled one-shot counter counts down from the value written to it to zero. It signals one expiry on the edge after it reaches zero.
- R6: After its one-shot expiry a counter stays at zero and raises no further expiry until its value register is written again. Its enable bit stays set.
- R7: A write to a value register (0x14 for counter 0, 0x1C for counter 1) replaces the count on that edge, taking precedence over the decrement. A write to a reload register (0x10, 0x18) changes only the reload value and leaves the running count alone.
- R8: The cause register is at 0x20, with bit 1 for counter 0 and bit 2 for counter 1. An expiry sets its bit whatever the mask holds. Writing a 0 to a bit clears it and writing a 1 leaves it as it is. If an expiry and a clear land on the same edge, the bit ends up set.
- R9: The mask register is at 0x24 and uses the same bit positions as the cause register. `irq` is high exactly when some cause bit and its mask bit are both set.
- R10: A counter whose enable bit is clear keeps its count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters step on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench walks through a periodic count of 3 and expects to read 3,2,1,0 repeating. A reload that fired one cycle early or late would break that pattern. It drives a one-shot count of 2 and checks that the counter sits at zero with no second expiry, which catches a design that re-fires or wraps to all-ones. It also checks that a cause bit set while masked stays invisible on `irq` until the mask opens, and that writing ones to the cause register does not clear it. A long random phase of writes, with many small counts, is compared every cycle against a bench model. That phase exposes a value write that loses to the decrement, a clear that beats a same-edge expiry, and a disabled counter that still moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W      = 32;
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_REL0   = 'h10;
    localparam int OFF_VAL0   = 'h14;
    localparam int CNT_STRIDE = 'h08;
    localparam int OFF_CAUSE  = 'h20;
    localparam int OFF_MASK   = 'h24;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic [CNT_W-1:0] rel;
        logic             armed;
    } cnt_state_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rld_mode,
    input  logic             wr_rel,
    input  logic             wr_val,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] rel,
    output logic             expire
);
    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (run) begin
            if (s_q.val != '0) begin
                s_d.val = s_q.val - 1'b1;
            end else if (rld_mode) begin
                s_d.val   = s_q.rel;
                s_d.armed = 1'b1;
                expire    = 1'b1;
            end else if (s_q.armed) begin
                s_d.armed = 1'b0;
                expire    = 1'b1;
            end
        end
        if (wr_val) begin
            s_d.val   = wdata;
            s_d.armed = 1'b1;
        end
        if (wr_rel) begin
            s_d.rel = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign val = s_q.val;
    assign rel = s_q.rel;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int NUM_CNT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] expire,
    input  logic               wr_cause,
    input  logic               wr_mask,
    input  logic [NUM_CNT-1:0] bits_wdata,
    output logic [NUM_CNT-1:0] cause,
    output logic [NUM_CNT-1:0] mask,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_CNT-1:0] cause;
        logic [NUM_CNT-1:0] mask;
    } irq_state_t;

    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_cause) s_d.cause = s_q.cause & bits_wdata;
        s_d.cause = s_d.cause | expire;
        if (wr_mask) s_d.mask = bits_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause = s_q.cause;
    assign mask  = s_q.mask;
    assign irq   = |(s_q.cause & s_q.mask);
endmodule

// File: rtl/dual_dn_timer.sv
module dual_dn_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int CTRL_W = 2 * NUM_CNT;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                          wr_ctrl, wr_cause, wr_mask;
    logic [NUM_CNT-1:0]            wr_rel, wr_val, expire;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val, cnt_rel;
    logic [NUM_CNT-1:0]            cause, mask;

    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
        wr_cause = reg_we && (reg_addr == ADDR_W'(OFF_CAUSE));
        wr_mask  = reg_we && (reg_addr == ADDR_W'(OFF_MASK));
        for (int i = 0; i < NUM_CNT; i++) begin
            wr_rel[i] = reg_we && (reg_addr == ADDR_W'(OFF_REL0 + i * CNT_STRIDE));
            wr_val[i] = reg_we && (reg_addr == ADDR_W'(OFF_VAL0 + i * CNT_STRIDE));
        end
        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = reg_wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        tmr_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (s_q.ctrl[2*g]),
            .rld_mode (s_q.ctrl[2*g+1]),
            .wr_rel   (wr_rel[g]),
            .wr_val   (wr_val[g]),
            .wdata    (reg_wdata),
            .val      (cnt_val[g]),
            .rel      (cnt_rel[g]),
            .expire   (expire[g])
        );
    end

    tmr_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .wr_cause   (wr_cause),
        .wr_mask    (wr_mask),
        .bits_wdata (reg_wdata[NUM_CNT:1]),
        .cause      (cause),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CTRL))  reg_rdata[CTRL_W-1:0]  = s_q.ctrl;
        if (reg_addr == ADDR_W'(OFF_CAUSE)) reg_rdata[NUM_CNT:1]   = cause;
        if (reg_addr == ADDR_W'(OFF_MASK))  reg_rdata[NUM_CNT:1]   = mask;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(OFF_REL0 + i * CNT_STRIDE)) reg_rdata = cnt_rel[i];
            if (reg_addr == ADDR_W'(OFF_VAL0 + i * CNT_STRIDE)) reg_rdata = cnt_val[i];
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_we,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [2*NUM_CNT-1:0]          ctrl,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_rel,
    input logic [NUM_CNT-1:0]            cause
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        logic val_wr;
        assign val_wr = reg_we && (reg_addr == ADDR_W'(OFF_VAL0 + g * CNT_STRIDE));

        p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[2*g] && cnt_val[g] != '0 && !val_wr) |=> (cnt_val[g] == $past(cnt_val[g]) - 1'b1));

        p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[2*g] && ctrl[2*g+1] && cnt_val[g] == '0 && !val_wr) |=> (cnt_val[g] == $past(cnt_rel[g])));

        p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[2*g] && ctrl[2*g+1] && cnt_val[g] == '0) |=> cause[g]);

        p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[2*g] && !ctrl[2*g+1] && cnt_val[g] == '0 && !val_wr) |=> (cnt_val[g] == '0));

        p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[2*g] && !val_wr) |=> $stable(cnt_val[g]));

        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cause[g] && !(reg_we && reg_addr == ADDR_W'(OFF_CAUSE))) |=> cause[g]);
    end
endmodule

bind dual_dn_timer tmr_chk #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .ctrl     (s_q.ctrl),
    .cnt_val  (cnt_val),
    .cnt_rel  (cnt_rel),
    .cause    (cause)
);

// File: tb/dual_dn_timer_tb.sv
module dual_dn_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dual_dn_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // bench model, built from the requirements
    logic [31:0] m_val [2];
    logic [31:0] m_rel [2];
    logic        m_arm [2];
    logic [3:0]  m_ctrl;
    logic [1:0]  m_cause, m_mask;

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin m_val[i] = '0; m_rel[i] = '0; m_arm[i] = 1'b0; end
        m_ctrl = '0; m_cause = '0; m_mask = '0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {28'b0, m_ctrl};
            8'h10: return m_rel[0];
            8'h14: return m_val[0];
            8'h18: return m_rel[1];
            8'h1C: return m_val[1];
            8'h20: return {29'b0, m_cause, 1'b0};
            8'h24: return {29'b0, m_mask, 1'b0};
            default: return '0;
        endcase
    endfunction

    task automatic model_step(input logic we, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nv [2];
        logic [31:0] nr [2];
        logic        na [2];
        logic [1:0]  ev, nc;
        ev = '0;
        for (int i = 0; i < 2; i++) begin
            nv[i] = m_val[i]; nr[i] = m_rel[i]; na[i] = m_arm[i];
            if (m_ctrl[2*i]) begin
                if (m_val[i] != 0) nv[i] = m_val[i] - 1;
                else if (m_ctrl[2*i+1]) begin nv[i] = m_rel[i]; na[i] = 1'b1; ev[i] = 1'b1; end
                else if (m_arm[i]) begin na[i] = 1'b0; ev[i] = 1'b1; end
            end
            if (we && a == 8'(8'h14 + 8*i)) begin nv[i] = d; na[i] = 1'b1; end
            if (we && a == 8'(8'h10 + 8*i)) nr[i] = d;
        end
        nc = m_cause;
        if (we && a == 8'h20) nc = nc & d[2:1];
        nc = nc | ev;
        if (we && a == 8'h24) m_mask = d[2:1];
        if (we && a == 8'h00) m_ctrl = d[3:0];
        m_cause = nc;
        for (int i = 0; i < 2; i++) begin m_val[i] = nv[i]; m_rel[i] = nr[i]; m_arm[i] = na[i]; end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, a0, b0;
        logic [31:0] exp4 [4];
        exp4[0] = 3; exp4[1] = 2; exp4[2] = 1; exp4[3] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        foreach (exp4[k]) begin end
        for (int a = 0; a <= 'h24; a += 4) begin
            rd(8'(a), r);
            chk(r == 0, "R1 reset reads zero", r, 0);
        end
        chk(irq == 1'b0, "R1 irq low after reset", {31'b0, irq}, 0);

        // R2: only low control bits stored; unmapped address ignored
        wr(8'h00, 32'hFFFF_FFF0);
        rd(8'h00, r);
        chk(r == 0, "R2 upper control bits ignored", r, 0);
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, r);
        chk(r == 0, "R2 unmapped address reads zero", r, 0);

        // R4: periodic reload 3 gives 3,2,1,0 repeating
        wr(8'h10, 3);
        wr(8'h14, 3);
        wr(8'h24, 32'h2);
        wr(8'h00, 32'h3);
        for (int k = 0; k < 8; k++) begin
            rd(8'h14, r);
            chk(r == exp4[k % 4], "R4 periodic count sequence", r, exp4[k % 4]);
        end
        rd(8'h20, r);
        chk(r[1] == 1'b1, "R8 cause set by periodic expiry", r, 32'h2);
        chk(irq == 1'b1, "R9 irq with mask open", {31'b0, irq}, 1);

        // R10: disabled counter freezes
        wr(8'h00, 0);
        rd(8'h14, a0);
        repeat (5) @(posedge clk);
        rd(8'h14, b0);
        chk(a0 == b0, "R10 disabled counter frozen", b0, a0);
        wr(8'h20, 32'hFFFF_FFF9);
        rd(8'h20, r);
        chk(r == 0, "R8 zero bits clear cause", r, 0);
        chk(irq == 1'b0, "R9 irq drops after clear", {31'b0, irq}, 0);

        // R5: one-shot counter 1 from 2
        wr(8'h24, 0);
        wr(8'h1C, 2);
        wr(8'h00, 32'h4);
        for (int k = 0; k < 6; k++) begin
            rd(8'h1C, r);
            chk(r == ((k < 2) ? 32'(2 - k) : 32'd0), "R5 one-shot count", r, (k < 2) ? 32'(2 - k) : 32'd0);
        end
        rd(8'h20, r);
        chk(r == 32'h4, "R8 one-shot cause set with mask closed", r, 32'h4);
        chk(irq == 1'b0, "R9 masked cause keeps irq low", {31'b0, irq}, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, r);
        chk(r == 32'h4, "R8 writing ones keeps cause", r, 32'h4);
        wr(8'h20, 0);
        repeat (6) @(posedge clk);
        rd(8'h20, r);
        chk(r == 0, "R6 no second one-shot expiry", r, 0);
        rd(8'h1C, r);
        chk(r == 0, "R6 one-shot holds zero", r, 0);
        rd(8'h00, r);
        chk(r == 32'h4, "R6 enable bit stays set", r, 32'h4);
        wr(8'h24, 32'h4);
        chk(irq == 1'b0, "R9 mask alone raises nothing", {31'b0, irq}, 0);
        wr(8'h1C, 1);
        repeat (3) @(posedge clk);
        rd(8'h20, r);
        chk(r == 32'h4, "R7 rewrite rearms one-shot", r, 32'h4);
        chk(irq == 1'b1, "R9 irq on masked-in one-shot", {31'b0, irq}, 1);

        // R3: free-running time base
        wr(8'h00, 0);
        wr(8'h24, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, 32'h3);
        rd(8'h14, a0);
        repeat (10) @(posedge clk);
        rd(8'h14, b0);
        chk((~b0) - (~a0) == 10, "R3 inverted count rises by one per cycle", (~b0) - (~a0), 10);
        chk(irq == 1'b0, "R9 time base interrupt masked", {31'b0, irq}, 0);

        // random phase against the model (R7, R8, R10 interplay)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
        void'($urandom(32'd1234));
        for (int c = 0; c < 4000; c++) begin
            logic        we;
            logic [7:0]  a;
            logic [31:0] d;
            logic [31:0] addrs [9];
            addrs[0] = 8'h00; addrs[1] = 8'h10; addrs[2] = 8'h14; addrs[3] = 8'h18;
            addrs[4] = 8'h1C; addrs[5] = 8'h20; addrs[6] = 8'h24; addrs[7] = 8'h30; addrs[8] = 8'h08;
            @(negedge clk);
            we = ($urandom % 5) == 0;
            a  = 8'(addrs[$urandom % 9]);
            case ($urandom % 4)
                0: d = 32'hFFFF_FFFF;
                1: d = $urandom;
                default: d = $urandom % 12;
            endcase
            reg_we = we; reg_addr = a; reg_wdata = d;
            #1;
            chk(reg_rdata == model_read(a), "R7 random readback", reg_rdata, model_read(a));
            chk(irq == |(m_cause & m_mask), "R9 random irq", {31'b0, irq}, {31'b0, |(m_cause & m_mask)});
            model_step(we, a, d);
        end
        @(negedge clk);
        reg_we = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule